// File: doc/BRIEF.md
# Dual-Controller Bonding Bridge

This block lets one memory-mapped burst master drive two identical memory-controller ports that run in lockstep. To the master, the pair looks like a single port twice as wide as either controller. Command fields are copied to both controllers. The two ready signals are combined into one. The wide write data and byte-enable buses are cut into one fixed slice per controller. The two read-data returns are glued back into one wide word. The master addresses bytes and the controllers address words, so the bridge drops the low byte-offset bits of the address on the way through.

The command and write paths are pure wiring plus one AND gate, so the master's handshake keeps its usual meaning. The read return path is registered. It adds one cycle of latency and gives the master a flop-driven data bus. With the default parameters there are two 64-bit controller ports, a 128-bit master bus of 8-bit symbols, a 28-bit byte address, a 24-bit word address and bursts of 1 to 4 beats.

Top module: `bond_bridge`

## Requirements
- R1: `m_ready` is high in a cycle only when `c0_ready` and `c1_ready` are both high in that same cycle. It has no register delay.
- R2: `m_burstbegin`, `m_read`, `m_write` and `m_size` appear unchanged on the matching outputs of both controllers in the same cycle.
- R3: Both controllers receive the same word address, which equals `m_addr` shifted right by log2 of the master bus width in bytes. With the defaults this is `m_addr[27:4]`.
- R4: `c0_wdata` carries `m_wdata[63:0]` and `c1_wdata` carries `m_wdata[127:64]` in the same cycle.
- R5: `c0_be` carries `m_be[7:0]` and `c1_be` carries `m_be[15:8]` in the same cycle. A write with partial enables changes only the enabled bytes of the read-back word.
- R6: `m_rvalid` is high one cycle after a cycle in which `c0_rvalid` and `c1_rvalid` are both high. It is low one cycle after any cycle in which either of them is low.
- R7: One cycle after both read-valids are high, `m_rdata` equals `{c1_rdata, c0_rdata}` as sampled in that earlier cycle. In every other cycle `m_rdata` holds its value.
- R8: While `rst` is high and directly after it is released, `m_rvalid` is 0 and `m_rdata` is all zeros.
- R9: Write bursts of 1 to 4 beats, followed by reads of the same words, return identical data in order. This holds even when the two controllers drop ready in different cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_burstbegin | input | 1 | Master: first beat of a burst |
| m_addr | input | 28 | Master byte address |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_size | input | 3 | Master burst length in beats (1 to 4) |
| m_wdata | input | 128 | Master write data |
| m_be | input | 16 | Master byte enables |
| m_ready | output | 1 | Both controllers accept |
| m_rdata | output | 128 | Joined read data, registered |
| m_rvalid | output | 1 | Joined read valid, registered |
| c0_burstbegin | output | 1 | Controller 0 burst begin |
| c0_addr | output | 24 | Controller 0 word address |
| c0_read | output | 1 | Controller 0 read request |
| c0_write | output | 1 | Controller 0 write request |
| c0_size | output | 3 | Controller 0 burst length |
| c0_wdata | output | 64 | Controller 0 write slice (low) |
| c0_be | output | 8 | Controller 0 byte enables (low) |
| c0_ready | input | 1 | Controller 0 ready |
| c0_rdata | input | 64 | Controller 0 read data |
| c0_rvalid | input | 1 | Controller 0 read valid |
| c1_burstbegin | output | 1 | Controller 1 burst begin |
| c1_addr | output | 24 | Controller 1 word address |
| c1_read | output | 1 | Controller 1 read request |
| c1_write | output | 1 | Controller 1 write request |
| c1_size | output | 3 | Controller 1 burst length |
| c1_wdata | output | 64 | Controller 1 write slice (high) |
| c1_be | output | 8 | Controller 1 byte enables (high) |
| c1_ready | input | 1 | Controller 1 ready |
| c1_rdata | input | 64 | Controller 1 read data |
| c1_rvalid | input | 1 | Controller 1 read valid |

## Verification
The ready, command, address and write-slice outputs are due in the same cycle as their inputs. The bench therefore drives those inputs on the falling edge and compares the outputs one time unit later, before any rising edge. The joined read valid and read data are due exactly one rising edge after the controller returns. Their directed checks drive the returns on one falling edge and sample on the next. In the end-to-end phase, each read request pushes its expected words into a queue. A monitor compares every master read beat with the head of that queue on the falling edge after it appears, while the two controller models stall ready on independent patterns.

// File: rtl/bond_pkg.sv
package bond_pkg;
  // number of bonded controller ports
  localparam int unsigned BOND_LANES = 2;

  // bits needed to encode a burst length of 1..max
  function automatic int unsigned size_bits(input int unsigned max_burst);
    return $clog2(max_burst) + 1;
  endfunction
endpackage

// File: rtl/bond_cmd_fanout.sv
module bond_cmd_fanout #(
  parameter int unsigned LANES = 2,
  parameter int unsigned MAW   = 28,
  parameter int unsigned OFS   = 4,
  parameter int unsigned SZW   = 3,
  localparam int unsigned CAW  = MAW - OFS
) (
  input  logic                       burstbegin_i,
  input  logic [MAW-1:0]             addr_i,
  input  logic                       read_i,
  input  logic                       write_i,
  input  logic [SZW-1:0]             size_i,
  input  logic [LANES-1:0]           lane_ready_i,
  output logic                       ready_o,
  output logic [LANES-1:0]           lane_burstbegin_o,
  output logic [LANES-1:0][CAW-1:0]  lane_addr_o,
  output logic [LANES-1:0]           lane_read_o,
  output logic [LANES-1:0]           lane_write_o,
  output logic [LANES-1:0][SZW-1:0]  lane_size_o
);
  logic [CAW-1:0] word_addr;

  // byte address -> word address of the combined bus
  assign word_addr = addr_i[MAW-1:OFS];

  // the master advances only when every bonded port accepts
  assign ready_o = &lane_ready_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_burstbegin_o[l] = burstbegin_i;
    assign lane_addr_o[l]       = word_addr;
    assign lane_read_o[l]       = read_i;
    assign lane_write_o[l]      = write_i;
    assign lane_size_o[l]       = size_i;
  end

  logic unused_low;
  assign unused_low = ^addr_i[OFS-1:0];
endmodule

// File: rtl/bond_wr_split.sv
module bond_wr_split #(
  parameter int unsigned LANES = 2,
  parameter int unsigned LDW   = 64,
  parameter int unsigned LBW   = 8
) (
  input  logic [LANES*LDW-1:0]       wdata_i,
  input  logic [LANES*LBW-1:0]       be_i,
  output logic [LANES-1:0][LDW-1:0]  lane_wdata_o,
  output logic [LANES-1:0][LBW-1:0]  lane_be_o
);
  // lane l owns the l-th contiguous slice, lane 0 at the bottom
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_wdata_o[l] = wdata_i[l*LDW +: LDW];
    assign lane_be_o[l]    = be_i[l*LBW +: LBW];
  end
endmodule

// File: rtl/bond_rd_join.sv
module bond_rd_join #(
  parameter int unsigned LANES = 2,
  parameter int unsigned LDW   = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES-1:0][LDW-1:0]  lane_rdata_i,
  input  logic [LANES-1:0]           lane_rvalid_i,
  output logic [LANES*LDW-1:0]       rdata_o,
  output logic                       rvalid_o
);
  logic [LANES*LDW-1:0] joined;
  logic                 all_valid;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign joined[l*LDW +: LDW] = lane_rdata_i[l];
  end

  assign all_valid = &lane_rvalid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= all_valid;
      if (all_valid) rdata_o <= joined;
    end
  end
endmodule

// File: rtl/bond_bridge.sv
module bond_bridge
  import bond_pkg::*;
#(
  parameter int unsigned LANE_DW   = 64,
  parameter int unsigned SYM_W     = 8,
  parameter int unsigned MAW       = 28,
  parameter int unsigned MAX_BURST = 4,
  localparam int unsigned MDW = BOND_LANES * LANE_DW,
  localparam int unsigned LBW = LANE_DW / SYM_W,
  localparam int unsigned MBW = MDW / SYM_W,
  localparam int unsigned OFS = $clog2(MBW),
  localparam int unsigned CAW = MAW - OFS,
  localparam int unsigned SZW = $clog2(MAX_BURST) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           m_burstbegin,
  input  logic [MAW-1:0] m_addr,
  input  logic           m_read,
  input  logic           m_write,
  input  logic [SZW-1:0] m_size,
  input  logic [MDW-1:0] m_wdata,
  input  logic [MBW-1:0] m_be,
  output logic           m_ready,
  output logic [MDW-1:0] m_rdata,
  output logic           m_rvalid,
  output logic           c0_burstbegin,
  output logic [CAW-1:0] c0_addr,
  output logic           c0_read,
  output logic           c0_write,
  output logic [SZW-1:0] c0_size,
  output logic [LANE_DW-1:0] c0_wdata,
  output logic [LBW-1:0] c0_be,
  input  logic           c0_ready,
  input  logic [LANE_DW-1:0] c0_rdata,
  input  logic           c0_rvalid,
  output logic           c1_burstbegin,
  output logic [CAW-1:0] c1_addr,
  output logic           c1_read,
  output logic           c1_write,
  output logic [SZW-1:0] c1_size,
  output logic [LANE_DW-1:0] c1_wdata,
  output logic [LBW-1:0] c1_be,
  input  logic           c1_ready,
  input  logic [LANE_DW-1:0] c1_rdata,
  input  logic           c1_rvalid
);
  localparam int unsigned L = BOND_LANES;

  logic [L-1:0]              ln_ready, ln_bb, ln_rd, ln_wr, ln_rvalid;
  logic [L-1:0][CAW-1:0]     ln_addr;
  logic [L-1:0][SZW-1:0]     ln_size;
  logic [L-1:0][LANE_DW-1:0] ln_wdata, ln_rdata;
  logic [L-1:0][LBW-1:0]     ln_be;

  assign ln_ready  = {c1_ready, c0_ready};
  assign ln_rvalid = {c1_rvalid, c0_rvalid};
  assign ln_rdata  = {c1_rdata, c0_rdata};

  bond_cmd_fanout #(.LANES(L), .MAW(MAW), .OFS(OFS), .SZW(SZW)) u_cmd (
    .burstbegin_i      (m_burstbegin),
    .addr_i            (m_addr),
    .read_i            (m_read),
    .write_i           (m_write),
    .size_i            (m_size),
    .lane_ready_i      (ln_ready),
    .ready_o           (m_ready),
    .lane_burstbegin_o (ln_bb),
    .lane_addr_o       (ln_addr),
    .lane_read_o       (ln_rd),
    .lane_write_o      (ln_wr),
    .lane_size_o       (ln_size)
  );

  bond_wr_split #(.LANES(L), .LDW(LANE_DW), .LBW(LBW)) u_wr (
    .wdata_i      (m_wdata),
    .be_i         (m_be),
    .lane_wdata_o (ln_wdata),
    .lane_be_o    (ln_be)
  );

  bond_rd_join #(.LANES(L), .LDW(LANE_DW)) u_rd (
    .clk           (clk),
    .rst           (rst),
    .lane_rdata_i  (ln_rdata),
    .lane_rvalid_i (ln_rvalid),
    .rdata_o       (m_rdata),
    .rvalid_o      (m_rvalid)
  );

  assign c0_burstbegin = ln_bb[0];
  assign c0_addr       = ln_addr[0];
  assign c0_read       = ln_rd[0];
  assign c0_write      = ln_wr[0];
  assign c0_size       = ln_size[0];
  assign c0_wdata      = ln_wdata[0];
  assign c0_be         = ln_be[0];

  assign c1_burstbegin = ln_bb[1];
  assign c1_addr       = ln_addr[1];
  assign c1_read       = ln_rd[1];
  assign c1_write      = ln_wr[1];
  assign c1_size       = ln_size[1];
  assign c1_wdata      = ln_wdata[1];
  assign c1_be         = ln_be[1];
endmodule

// File: rtl/bond_bridge_chk.sv
module bond_bridge_chk #(
  parameter int unsigned LANE_DW   = 64,
  parameter int unsigned SYM_W     = 8,
  parameter int unsigned MAW       = 28,
  parameter int unsigned MAX_BURST = 4,
  localparam int unsigned MDW = 2 * LANE_DW,
  localparam int unsigned LBW = LANE_DW / SYM_W,
  localparam int unsigned MBW = MDW / SYM_W,
  localparam int unsigned OFS = $clog2(MBW),
  localparam int unsigned CAW = MAW - OFS,
  localparam int unsigned SZW = $clog2(MAX_BURST) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           m_burstbegin,
  input logic [MAW-1:0] m_addr,
  input logic           m_read,
  input logic           m_write,
  input logic [SZW-1:0] m_size,
  input logic [MDW-1:0] m_wdata,
  input logic [MBW-1:0] m_be,
  input logic           m_ready,
  input logic [MDW-1:0] m_rdata,
  input logic           m_rvalid,
  input logic           c0_burstbegin,
  input logic [CAW-1:0] c0_addr,
  input logic           c0_read,
  input logic           c0_write,
  input logic [SZW-1:0] c0_size,
  input logic [LANE_DW-1:0] c0_wdata,
  input logic [LBW-1:0] c0_be,
  input logic           c0_ready,
  input logic [LANE_DW-1:0] c0_rdata,
  input logic           c0_rvalid,
  input logic           c1_burstbegin,
  input logic [CAW-1:0] c1_addr,
  input logic           c1_read,
  input logic           c1_write,
  input logic [SZW-1:0] c1_size,
  input logic [LANE_DW-1:0] c1_wdata,
  input logic [LBW-1:0] c1_be,
  input logic           c1_ready,
  input logic [LANE_DW-1:0] c1_rdata,
  input logic           c1_rvalid
);
  // R1
  ready_join_chk: assert property (@(posedge clk) disable iff (rst)
    (!c0_ready || !c1_ready) |-> !m_ready);

  // R2
  cmd_bcast_chk: assert property (@(posedge clk) disable iff (rst)
    (c0_read == m_read) && (c1_read == m_read) && (c0_write == m_write) &&
    (c1_write == m_write) && (c0_burstbegin == m_burstbegin) &&
    (c1_burstbegin == m_burstbegin) && (c0_size == m_size) && (c1_size == m_size));

  // R3
  word_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (c0_addr == c1_addr) && (c0_addr == m_addr[MAW-1:OFS]));

  // R4
  wr_slice_chk: assert property (@(posedge clk) disable iff (rst)
    {c1_wdata, c0_wdata} == m_wdata);

  // R5
  be_slice_chk: assert property (@(posedge clk) disable iff (rst)
    {c1_be, c0_be} == m_be);

  // R6
  rvalid_set_chk: assert property (@(posedge clk) disable iff (rst)
    (c0_rvalid && c1_rvalid) |=> m_rvalid);

  // R6
  rvalid_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !(c0_rvalid && c1_rvalid) |=> !m_rvalid);

  // R7
  rdata_join_chk: assert property (@(posedge clk) disable iff (rst)
    (c0_rvalid && c1_rvalid) |=> (m_rdata == {$past(c1_rdata), $past(c0_rdata)}));

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(c0_rvalid && c1_rvalid) |=> $stable(m_rdata));
endmodule

bind bond_bridge bond_bridge_chk #(
  .LANE_DW(LANE_DW), .SYM_W(SYM_W), .MAW(MAW), .MAX_BURST(MAX_BURST)
) u_chk (.*);

// File: tb/sim_bond_bridge.sv
module sim_bond_bridge;
  localparam int LDW = 64, MDW = 128, MAW = 28, CAW = 24, MBW = 16, LBW = 8, SZW = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic m_burstbegin = 0, m_read = 0, m_write = 0;
  logic [MAW-1:0] m_addr = '0;
  logic [SZW-1:0] m_size = 3'd1;
  logic [MDW-1:0] m_wdata = '0;
  logic [MBW-1:0] m_be = '0;
  logic m_ready, m_rvalid;
  logic [MDW-1:0] m_rdata;
  logic c0_burstbegin, c0_read, c0_write, c1_burstbegin, c1_read, c1_write;
  logic [CAW-1:0] c0_addr, c1_addr;
  logic [SZW-1:0] c0_size, c1_size;
  logic [LDW-1:0] c0_wdata, c1_wdata, c0_rdata, c1_rdata;
  logic [LBW-1:0] c0_be, c1_be;
  logic c0_ready, c1_ready, c0_rvalid, c1_rvalid;

  // directed drive vs. lockstep slave models
  logic dir_mode = 1'b1;
  logic d_rdy0 = 0, d_rdy1 = 0, d_rv0 = 0, d_rv1 = 0;
  logic [LDW-1:0] d_rd0 = '0, d_rd1 = '0;
  logic s_rdy0 = 0, s_rdy1 = 0, s_rv = 0;
  logic [LDW-1:0] s_rd0 = '0, s_rd1 = '0;

  assign c0_ready  = dir_mode ? d_rdy0 : s_rdy0;
  assign c1_ready  = dir_mode ? d_rdy1 : s_rdy1;
  assign c0_rvalid = dir_mode ? d_rv0  : s_rv;
  assign c1_rvalid = dir_mode ? d_rv1  : s_rv;
  assign c0_rdata  = dir_mode ? d_rd0  : s_rd0;
  assign c1_rdata  = dir_mode ? d_rd1  : s_rd1;

  bond_bridge u0 (.*);

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [MDW-1:0] act,
                     input logic [MDW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- lockstep slave models ----------------
  logic [LDW-1:0] mem0 [64];
  logic [LDW-1:0] mem1 [64];
  logic [MDW-1:0] ret_q[$];
  int             ret_due[$];
  int             scyc = 0, wr_beat = 0, beat;
  logic [5:0]     idx;
  logic [15:0]    lfsr = 16'hACE1;
  logic [1:0]     stall_mode = 2'd0;

  // both controllers commit only on the joined ready (bonded lockstep)
  always @(posedge clk) begin
    scyc = scyc + 1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!dir_mode && !rst && m_ready) begin
      if (m_write) begin
        beat = m_burstbegin ? 0 : wr_beat;
        idx  = c0_addr[5:0] + beat[5:0];
        for (int b = 0; b < LBW; b++) begin
          if (c0_be[b]) mem0[idx][b*8 +: 8] = c0_wdata[b*8 +: 8];
          if (c1_be[b]) mem1[idx][b*8 +: 8] = c1_wdata[b*8 +: 8];
        end
        wr_beat = beat + 1;
      end
      if (m_read) begin
        for (int b = 0; b < int'(c0_size); b++) begin
          idx = c0_addr[5:0] + b[5:0];
          ret_q.push_back({mem1[idx], mem0[idx]});
          ret_due.push_back(scyc + 2 + b);
        end
      end
    end
  end

  always @(negedge clk) begin
    s_rdy0 = stall_mode[0] ? (lfsr[2] | lfsr[9]) : 1'b1;
    s_rdy1 = stall_mode[1] ? (lfsr[5] | lfsr[11]) : 1'b1;
    if (ret_q.size() > 0 && scyc >= ret_due[0]) begin
      s_rv = 1'b1;
      {s_rd1, s_rd0} = ret_q.pop_front();
      void'(ret_due.pop_front());
    end else begin
      s_rv = 1'b0;
    end
  end

  // ---------------- scoreboard ----------------
  logic [MDW-1:0] shadow [64];
  logic [MDW-1:0] exp_q[$];

  always @(negedge clk) begin
    if (!dir_mode && m_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected beat", m_rdata, '0);
      else begin
        logic [MDW-1:0] e;
        e = exp_q.pop_front();
        chk(m_rdata == e, "R9 read-back", m_rdata, e);
      end
    end
  end

  task automatic wait_accept();
    @(posedge clk);
    while (!m_ready) @(posedge clk);
  endtask

  task automatic wr_burst(input int w, input int n, input logic [MDW-1:0] base,
                          input logic [MBW-1:0] be);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      m_addr = MAW'(w) << 4; m_size = SZW'(n); m_write = 1; m_read = 0;
      m_burstbegin = (b == 0); m_wdata = base + MDW'(b); m_be = be;
      wait_accept();
      for (int k = 0; k < MBW; k++)
        if (be[k]) shadow[(w + b) & 63][k*8 +: 8] = m_wdata[k*8 +: 8];
    end
    @(negedge clk);
    m_write = 0; m_burstbegin = 0;
  endtask

  task automatic rd_burst(input int w, input int n);
    @(negedge clk);
    m_addr = MAW'(w) << 4; m_size = SZW'(n); m_read = 1; m_write = 0; m_burstbegin = 1;
    wait_accept();
    for (int b = 0; b < n; b++) exp_q.push_back(shadow[(w + b) & 63]);
    @(negedge clk);
    m_read = 0; m_burstbegin = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem0[i] = '0; mem1[i] = '0; shadow[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R8: during reset
    chk(!m_rvalid && m_rdata == '0, "R8 in reset", {m_rvalid, m_rdata[MDW-2:0]}, '0);
    rst = 0;
    @(negedge clk);
    chk(!m_rvalid && m_rdata == '0, "R8 after reset", {m_rvalid, m_rdata[MDW-2:0]}, '0);

    // R1: every ready combination, same cycle
    for (int r = 0; r < 4; r++) begin
      d_rdy0 = r[0]; d_rdy1 = r[1];
      #1 chk(m_ready == (r == 3), "R1 ready join", MDW'(m_ready), MDW'(r == 3));
      @(negedge clk);
    end

    // R2 and R3: command broadcast and word address
    m_addr = 28'hABCDEF5; m_size = 3'd3; m_burstbegin = 1; m_read = 1; m_write = 0;
    #1 chk(c0_addr == 24'hABCDEF && c1_addr == 24'hABCDEF, "R3 word address",
           {c1_addr, c0_addr}, {24'hABCDEF, 24'hABCDEF});
    chk(c0_read && c1_read && !c0_write && !c1_write && c0_burstbegin && c1_burstbegin &&
        c0_size == 3'd3 && c1_size == 3'd3, "R2 read broadcast",
        {c1_read, c0_read, c1_write, c0_write, c1_size, c0_size}, {4'b1100, 3'd3, 3'd3});
    @(negedge clk);
    m_addr = 28'h0000010; m_size = 3'd4; m_burstbegin = 0; m_read = 0; m_write = 1;
    #1 chk(!c0_read && !c1_read && c0_write && c1_write && !c0_burstbegin &&
           !c1_burstbegin && c0_size == 3'd4 && c1_size == 3'd4 && c0_addr == 24'd1,
           "R2 write broadcast", {c1_write, c0_write, c1_size, c0_size, c0_addr},
           {2'b11, 3'd4, 3'd4, 24'd1});

    // R4 and R5: lane slices
    m_wdata = 128'h1111_2222_3333_4444_5555_6666_7777_8888; m_be = 16'hA55A;
    #1 chk(c0_wdata == 64'h5555_6666_7777_8888 && c1_wdata == 64'h1111_2222_3333_4444,
           "R4 write slices", {c1_wdata, c0_wdata}, m_wdata);
    chk(c0_be == 8'h5A && c1_be == 8'hA5, "R5 byte-enable slices",
        MDW'({c1_be, c0_be}), MDW'(16'hA55A));
    @(negedge clk);
    m_write = 0; m_be = '0;

    // R6 and R7: only one lane valid -> nothing joined
    d_rd0 = 64'hAAAA_0000_0000_0001; d_rd1 = 64'hBBBB_0000_0000_0002;
    d_rv0 = 1; d_rv1 = 0;
    @(negedge clk);
    chk(!m_rvalid, "R6 single lane valid", MDW'(m_rvalid), '0);
    chk(m_rdata == '0, "R7 hold on single valid", m_rdata, '0);
    d_rv0 = 0; d_rv1 = 1;
    @(negedge clk);
    chk(!m_rvalid, "R6 other lane valid", MDW'(m_rvalid), '0);
    d_rv0 = 1; d_rv1 = 1;
    @(negedge clk);
    chk(m_rvalid, "R6 both valid", MDW'(m_rvalid), MDW'(1));
    chk(m_rdata == {d_rd1, d_rd0}, "R7 join order", m_rdata, {d_rd1, d_rd0});
    d_rv0 = 0; d_rv1 = 0; d_rd0 = '1; d_rd1 = '1;
    @(negedge clk);
    chk(!m_rvalid, "R6 valid drops", MDW'(m_rvalid), '0);
    chk(m_rdata == {64'hBBBB_0000_0000_0002, 64'hAAAA_0000_0000_0001}, "R7 hold",
        m_rdata, {64'hBBBB_0000_0000_0002, 64'hAAAA_0000_0000_0001});

    // R9: end-to-end bursts under each stall pattern
    dir_mode = 0;
    for (int mode = 0; mode < 4; mode++) begin
      stall_mode = 2'(mode);
      for (int n = 1; n <= 4; n++)
        wr_burst(mode * 16 + n * 3, n,
                 {32'(mode), 32'hC0DE_0000 + 32'(n), 32'h1234_5678, 32'(n * 7)}, '1);
      for (int n = 4; n >= 1; n--) rd_burst(mode * 16 + n * 3, n);
    end

    // R5: partial byte enables merge into the stored word
    stall_mode = 2'd3;
    wr_burst(62, 2, {4{32'h0F0F_0F0F}}, '1);
    wr_burst(62, 2, {4{32'hF0F0_F0F0}}, 16'h0FF0);
    rd_burst(62, 2);

    while (exp_q.size() > 0 || ret_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule